// File: doc/BRIEF.md
# Half/Full-Duplex MII Transmit Controller

This block puts one buffered frame onto a nibble-wide media-independent interface, following the carrier-sense, multiple-access and collision-detect rules. Each clock is one transmit-clock period, and each transmitted nibble takes one clock. A request (`frame_go`) and a byte count (`frame_len`) start a frame. The block reads the frame bytes from a local replayable store through `rd_idx`/`rd_byte`. That store returns the byte for any index in the same cycle and holds the complete frame, preamble included. The block drives `tx_en` and `txd` and watches carrier sense (`crs`) and collision (`col`).

In half duplex the block waits for a quiet line before it starts. On a collision it stops the data, sends a jam, and waits a random number of slot times chosen by truncated binary exponential backoff. It then replays the frame from byte 0 of the local store. After a frame, or after a frame is given up, it holds the line quiet for the inter-frame gap and then pulses `done` with the frame status: lost carrier, number of collisions, and excessive collisions. In full duplex both `crs` and `col` are ignored.

The states are IDLE, DEFER, SEND, JAM, BACKOFF and GAP. The transitions are:
- IDLE→DEFER on `frame_go`.
- DEFER→SEND when the line is clear, or at once in full duplex.
- SEND→JAM on a collision in half duplex.
- SEND→GAP after the last nibble.
- JAM→BACKOFF after the eighth jam nibble while attempts remain.
- JAM→GAP after the eighth jam nibble once the attempt limit is reached.
- BACKOFF→DEFER when the wait counter reaches zero.
- GAP→IDLE after the gap.

Top module: `csma_tx_ctrl`

## Requirements
- R1: In half duplex, SEND is entered only from DEFER at a clock edge where `crs` is low. `tx_en` rises in the cycle after that edge, which is two cycles after the edge that samples `frame_go` when the line is already clear.
- R2: A frame of L bytes (1 ≤ L) is sent as 2·L consecutive cycles with `tx_en` high. Nibble j is byte j/2 of the store, read through `rd_idx`, with the low nibble `[3:0]` sent before the high nibble `[7:4]`.
- R3: In half duplex, `st_lost` is reported as 1 when `crs` was not high in any of the first SLOT_NIB nibble cycles of the final attempt. The frame is still sent in full.
- R4: In half duplex, when `col` is high at the edge ending a data nibble, the data stops. The next 8 cycles carry the jam: `tx_en` high and `txd` = 4'h5.
- R5: After the jam, `tx_en` stays low for S·SLOT_NIB+2 cycles, where S lies in 0..2^min(n,BO_CAP)−1 and n is the collision count so far. The frame is then replayed from byte 0.
- R6: After the last nibble of a frame, `tx_en` stays low for IFG_NIB cycles. `done` is then high for exactly one cycle, and a new `frame_go` may be accepted in that cycle.
- R7: In full duplex, `crs` neither delays the start nor marks the frame as lost, and `col` neither cuts the frame nor is counted.
- R8: After MAX_TRIES collisions the frame is given up after its jam. `done` then reports `st_excess`=1 and `st_colls`=MAX_TRIES.
- R9: At `done`, `st_colls` holds the number of collisions the frame met, and `st_excess` is 0 when the frame was sent.
- R10: After reset, `tx_en`, `txd`, `done`, `st_lost`, `st_excess` and `st_colls` are all 0.
- R11: `txd` is 0 in every cycle where `tx_en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transmit clock, one nibble per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| full_duplex | input | 1 | 1 selects full duplex (carrier and collision ignored) |
| frame_go | input | 1 | Start request, accepted in IDLE |
| frame_len | input | LEN_W | Frame length in bytes, latched at start |
| rd_idx | output | LEN_W | Byte index into the local frame store |
| rd_byte | input | 8 | Store byte at `rd_idx`, same cycle |
| crs | input | 1 | Carrier sense from the line |
| col | input | 1 | Collision indication from the line |
| tx_en | output | 1 | Transmit enable |
| txd | output | 4 | Transmit nibble |
| done | output | 1 | One-cycle pulse when a frame is finished or given up |
| st_lost | output | 1 | Lost-carrier status of the last frame |
| st_excess | output | 1 | Excessive-collision status of the last frame |
| st_colls | output | CW | Collision count of the last frame |

## Verification
The main path is tried in four ways:
- A clear line, which fixes the start latency and the nibble order.
- Carrier held high before the start, which separates true deferral from a start that ignores the carrier.
- Carrier that arrives before, late, or never within the slot, which separates a correct lost-carrier flag from one that is always set or never set.
- Full duplex with carrier and collision both forced high, which shows that neither input reaches the transmit path in that mode.

Collisions are placed on the first nibble, a middle nibble and the last nibble. Each backoff wait is measured against the slot grid and the allowed range. A run of sixteen collisions exercises the abandon path and the excessive-collision status.

// File: rtl/csma_tx_pkg.sv
package csma_tx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DEFER,
        ST_SEND,
        ST_JAM,
        ST_BACKOFF,
        ST_GAP
    } tx_state_t;

    localparam logic [3:0] JAM_NIBBLE = 4'h5;

endpackage

// File: rtl/csma_lfsr.sv
module csma_lfsr #(
    parameter int             W    = 16,
    parameter logic [W-1:0]   TAPS = 16'hB400,
    parameter logic [W-1:0]   SEED = 16'hACE1
) (
    input  logic         clk,
    input  logic         rst_n,
    output logic [W-1:0] value
);

    logic [W-1:0] reg_q;

    // Galois form, shifting right; the feedback is the bit that leaves.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            reg_q <= SEED;
        else if (reg_q[0])
            reg_q <= (reg_q >> 1) ^ TAPS;
        else
            reg_q <= reg_q >> 1;
    end

    assign value = reg_q;

endmodule

// File: rtl/csma_backoff_pick.sv
module csma_backoff_pick #(
    parameter int BO_CAP   = 10,
    parameter int SLOT_NIB = 128,
    parameter int CW       = 5,
    parameter int BO_W     = BO_CAP + $clog2(SLOT_NIB) + 1
) (
    input  logic [BO_CAP-1:0] rand_bits,
    input  logic [CW-1:0]     coll_n,
    output logic [BO_W-1:0]   wait_cycles
);

    logic [CW-1:0]     exp_k;
    logic [BO_CAP-1:0] one_sh;
    logic [BO_CAP-1:0] mask;
    logic [BO_CAP-1:0] slots;

    // Truncated exponent: the range stops growing at BO_CAP.
    always_comb begin
        exp_k = (coll_n > CW'(BO_CAP)) ? CW'(BO_CAP) : coll_n;
    end

    // A shift of BO_CAP wraps to zero, so the mask becomes all ones.
    assign one_sh      = {{(BO_CAP-1){1'b0}}, 1'b1} << exp_k;
    assign mask        = one_sh - {{(BO_CAP-1){1'b0}}, 1'b1};
    assign slots       = rand_bits & mask;
    assign wait_cycles = BO_W'(slots) * BO_W'(SLOT_NIB);

endmodule

// File: rtl/csma_carrier_watch.sv
module csma_carrier_watch #(
    parameter int SLOT_NIB = 128,
    parameter int WW       = $clog2(SLOT_NIB + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    input  logic crs_seen_in,
    output logic carrier_ok
);

    logic [WW-1:0] win_q;
    logic          seen_q;
    logic          in_window;

    assign in_window = active && (win_q < WW'(SLOT_NIB));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            win_q  <= '0;
            seen_q <= 1'b0;
        end else if (!active) begin
            win_q  <= '0;
            seen_q <= 1'b0;
        end else begin
            if (in_window)
                win_q <= win_q + 1'b1;
            if (in_window && crs_seen_in)
                seen_q <= 1'b1;
        end
    end

    // Includes the current cycle so that a frame ending now is judged in full.
    assign carrier_ok = seen_q || (in_window && crs_seen_in);

endmodule

// File: rtl/csma_tx_ctrl.sv
module csma_tx_ctrl
    import csma_tx_pkg::*;
#(
    parameter int LEN_W     = 11,
    parameter int SLOT_NIB  = 128,
    parameter int IFG_NIB   = 24,
    parameter int JAM_NIB   = 8,
    parameter int MAX_TRIES = 16,
    parameter int BO_CAP    = 10,
    localparam int CW       = $clog2(MAX_TRIES + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             full_duplex,
    input  logic             frame_go,
    input  logic [LEN_W-1:0] frame_len,
    output logic [LEN_W-1:0] rd_idx,
    input  logic [7:0]       rd_byte,
    input  logic             crs,
    input  logic             col,
    output logic             tx_en,
    output logic [3:0]       txd,
    output logic             done,
    output logic             st_lost,
    output logic             st_excess,
    output logic [CW-1:0]    st_colls
);

    localparam int NIB_W = LEN_W + 1;
    localparam int JW    = (JAM_NIB > 1) ? $clog2(JAM_NIB) : 1;
    localparam int GW    = $clog2(IFG_NIB + 1);
    localparam int BO_W  = BO_CAP + $clog2(SLOT_NIB) + 1;

    tx_state_t state, nxt;

    logic [LEN_W-1:0] len_q;
    logic [NIB_W-1:0] nib_q;
    logic [NIB_W-1:0] last_nib;
    logic [JW-1:0]    jam_q;
    logic [GW-1:0]    gap_q;
    logic [BO_W-1:0]  bo_q;
    logic [CW-1:0]    colls_q;
    logic [15:0]      rnd;
    logic [BO_W-1:0]  bo_load;
    logic             col_hit;
    logic             line_clear;
    logic             nib_end;
    logic             jam_end;
    logic             gap_end;
    logic             carrier_ok;

    assign col_hit    = col && !full_duplex;
    assign line_clear = full_duplex || !crs;
    assign last_nib   = {len_q, 1'b0} - NIB_W'(1);
    assign nib_end    = (nib_q == last_nib);
    assign jam_end    = (jam_q == JW'(JAM_NIB - 1));
    assign gap_end    = (gap_q == GW'(IFG_NIB - 1));
    assign rd_idx     = nib_q[NIB_W-1:1];

    csma_lfsr #(
        .W    (16),
        .TAPS (16'hB400),
        .SEED (16'hACE1)
    ) u_rng (
        .clk   (clk),
        .rst_n (rst_n),
        .value (rnd)
    );

    csma_backoff_pick #(
        .BO_CAP   (BO_CAP),
        .SLOT_NIB (SLOT_NIB),
        .CW       (CW),
        .BO_W     (BO_W)
    ) u_pick (
        .rand_bits   (rnd[BO_CAP-1:0]),
        .coll_n      (colls_q),
        .wait_cycles (bo_load)
    );

    csma_carrier_watch #(
        .SLOT_NIB (SLOT_NIB)
    ) u_crs (
        .clk         (clk),
        .rst_n       (rst_n),
        .active      (state == ST_SEND),
        .crs_seen_in (crs && !full_duplex),
        .carrier_ok  (carrier_ok)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= ST_IDLE;
        else
            state <= nxt;
    end

    // Next state
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:    if (frame_go)   nxt = ST_DEFER;
            ST_DEFER:   if (line_clear) nxt = ST_SEND;
            ST_SEND: begin
                if (col_hit)      nxt = ST_JAM;
                else if (nib_end) nxt = ST_GAP;
            end
            ST_JAM: begin
                if (jam_end)
                    nxt = (colls_q == CW'(MAX_TRIES)) ? ST_GAP : ST_BACKOFF;
            end
            ST_BACKOFF: if (bo_q == '0) nxt = ST_DEFER;
            ST_GAP:     if (gap_end)    nxt = ST_IDLE;
            default:    nxt = ST_IDLE;
        endcase
    end

    // Outputs toward the line
    always_comb begin
        tx_en = 1'b0;
        txd   = 4'h0;
        unique case (state)
            ST_SEND: begin
                tx_en = 1'b1;
                txd   = nib_q[0] ? rd_byte[7:4] : rd_byte[3:0];
            end
            ST_JAM: begin
                tx_en = 1'b1;
                txd   = JAM_NIBBLE;
            end
            default: begin
                tx_en = 1'b0;
                txd   = 4'h0;
            end
        endcase
    end

    // Counters for the frame, the jam, the backoff and the gap
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            len_q   <= '0;
            nib_q   <= '0;
            jam_q   <= '0;
            gap_q   <= '0;
            bo_q    <= '0;
            colls_q <= '0;
        end else begin
            if (state == ST_IDLE && frame_go) begin
                len_q   <= frame_len;
                colls_q <= '0;
            end
            if (state == ST_DEFER)
                nib_q <= '0;
            else if (state == ST_SEND && !col_hit && !nib_end)
                nib_q <= nib_q + NIB_W'(1);
            if (state == ST_SEND && col_hit)
                colls_q <= colls_q + CW'(1);
            if (state == ST_JAM)
                jam_q <= jam_end ? '0 : jam_q + JW'(1);
            else
                jam_q <= '0;
            if (state == ST_JAM && jam_end)
                bo_q <= bo_load;
            else if (state == ST_BACKOFF && bo_q != '0)
                bo_q <= bo_q - BO_W'(1);
            if (state == ST_GAP)
                gap_q <= gap_q + GW'(1);
            else
                gap_q <= '0;
        end
    end

    // Frame status, latched on entry to the gap
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_lost   <= 1'b0;
            st_excess <= 1'b0;
            st_colls  <= '0;
            done      <= 1'b0;
        end else begin
            done <= (state == ST_GAP) && gap_end;
            if (state == ST_SEND && !col_hit && nib_end) begin
                st_lost   <= !full_duplex && !carrier_ok;
                st_excess <= 1'b0;
                st_colls  <= colls_q;
            end else if (state == ST_JAM && jam_end && colls_q == CW'(MAX_TRIES)) begin
                st_lost   <= 1'b0;
                st_excess <= 1'b1;
                st_colls  <= colls_q;
            end
        end
    end

endmodule

// File: rtl/csma_tx_ctrl_chk.sv
module csma_tx_ctrl_chk
    import csma_tx_pkg::*;
#(
    parameter int IFG_NIB   = 24,
    parameter int MAX_TRIES = 16,
    parameter int CW        = 5
) (
    input logic          clk,
    input logic          rst_n,
    input logic          full_duplex,
    input logic          crs,
    input logic          col,
    input logic          tx_en,
    input logic [3:0]    txd,
    input logic          done,
    input logic          st_excess,
    input logic [CW-1:0] st_colls,
    input tx_state_t     state
);

    logic [15:0] quiet_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            quiet_q <= '0;
        else if (tx_en)
            quiet_q <= '0;
        else if (quiet_q != 16'hFFFF)
            quiet_q <= quiet_q + 16'd1;
    end

    a_r1_no_start_on_carrier: assert property (@(posedge clk) disable iff (!rst_n)
        (!full_duplex && crs && !tx_en) |=> !tx_en);

    a_r1_start_from_defer: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_en) |-> $past(state) == ST_DEFER);

    a_r4_jam_after_col: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SEND && col && !full_duplex) |=> (tx_en && txd == 4'h5));

    a_r6_gap_before_done: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (quiet_q >= 16'(IFG_NIB)));

    a_r7_fd_no_jam: assert property (@(posedge clk) disable iff (!rst_n)
        (full_duplex && state == ST_SEND) |=> state != ST_JAM);

    a_r8_excess_count: assert property (@(posedge clk) disable iff (!rst_n)
        (done && st_excess) |-> st_colls == CW'(MAX_TRIES));

    a_r11_quiet_data: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_en |-> txd == 4'h0);

endmodule

bind csma_tx_ctrl csma_tx_ctrl_chk #(
    .IFG_NIB   (IFG_NIB),
    .MAX_TRIES (MAX_TRIES),
    .CW        (CW)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .full_duplex (full_duplex),
    .crs         (crs),
    .col         (col),
    .tx_en       (tx_en),
    .txd         (txd),
    .done        (done),
    .st_excess   (st_excess),
    .st_colls    (st_colls),
    .state       (state)
);

// File: tb/sim_csma_tx_ctrl.sv
module sim_csma_tx_ctrl;

    localparam int LEN_W = 6;
    localparam int SLOT  = 8;
    localparam int IFG   = 6;
    localparam int MAXT  = 16;
    localparam int CAP   = 10;
    localparam int CW    = $clog2(MAXT + 1);

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             full_duplex = 1'b0;
    logic             frame_go = 1'b0;
    logic [LEN_W-1:0] frame_len = '0;
    logic [LEN_W-1:0] rd_idx;
    logic [7:0]       rd_byte;
    logic             crs = 1'b0;
    logic             col = 1'b0;
    logic             tx_en;
    logic [3:0]       txd;
    logic             done;
    logic             st_lost;
    logic             st_excess;
    logic [CW-1:0]    st_colls;

    int n_checks = 0;
    int n_fail   = 0;

    always #2 clk = ~clk;

    function automatic logic [7:0] pat(input int i);
        return 8'((i * 29 + 8'h3C) & 8'hFF);
    endfunction

    assign rd_byte = pat(int'(rd_idx));

    csma_tx_ctrl #(
        .LEN_W     (LEN_W),
        .SLOT_NIB  (SLOT),
        .IFG_NIB   (IFG),
        .JAM_NIB   (8),
        .MAX_TRIES (MAXT),
        .BO_CAP    (CAP)
    ) u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .full_duplex (full_duplex),
        .frame_go    (frame_go),
        .frame_len   (frame_len),
        .rd_idx      (rd_idx),
        .rd_byte     (rd_byte),
        .crs         (crs),
        .col         (col),
        .tx_en       (tx_en),
        .txd         (txd),
        .done        (done),
        .st_lost     (st_lost),
        .st_excess   (st_excess),
        .st_colls    (st_colls)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // R11 on every clock
    always @(negedge clk) begin
        if (rst_n && !tx_en)
            chk(txd == 4'h0, "R11", "txd while idle", int'(txd), 0);
    end

    // One frame, driven and compared cycle by cycle.
    // crs_from: first nibble with carrier high (-1 = never); pre_crs: carrier
    // cycles held high before the start.
    task automatic run_frame(input int len, input bit fd, input int ncoll,
                             input int col_nib, input int crs_from, input int pre_crs);
        int  attempt = 0;
        bit  finished = 0;
        bit  exp_lost;
        exp_lost = !fd && !(crs_from >= 0 && crs_from < SLOT && crs_from < 2 * len);
        @(negedge clk);
        full_duplex = fd;
        frame_len   = LEN_W'(len);
        frame_go    = 1'b1;
        crs         = (pre_crs > 0);
        @(negedge clk);
        frame_go = 1'b0;
        chk(!tx_en, "R1", "tx_en one cycle after go", int'(tx_en), 0);
        if (!fd) begin
            for (int k = 1; k < pre_crs; k++) begin
                @(negedge clk);
                chk(!tx_en, "R1", "deferring on carrier", int'(tx_en), 0);
            end
            crs = 1'b0;
        end
        @(negedge clk);
        chk(tx_en, "R1", "start after clear line", int'(tx_en), 1);
        while (!finished) begin
            bit collided = 0;
            for (int j = 0; j < 2 * len; j++) begin
                logic [7:0] b = pat(j / 2);
                logic [3:0] e = (j % 2 == 1) ? b[7:4] : b[3:0];
                chk(tx_en && txd == e, (attempt > 0) ? "R5" : "R2", "data nibble",
                    int'(txd), int'(e));
                crs = (crs_from >= 0 && j >= crs_from) || (fd && pre_crs > 0);
                col = (attempt < ncoll && j == col_nib);
                @(negedge clk);
                if (col && !fd) begin
                    collided = 1;
                    col = 1'b0;
                    break;
                end
                col = 1'b0;
            end
            crs = 1'b0;
            if (collided) begin
                for (int q = 0; q < 8; q++) begin
                    chk(tx_en && txd == 4'h5, "R4", "jam nibble", int'(txd), 5);
                    @(negedge clk);
                end
                attempt++;
                if (attempt == MAXT) begin
                    for (int g = 0; g < IFG; g++) begin
                        chk(!tx_en && !done, "R8", "quiet after last jam", int'(tx_en), 0);
                        @(negedge clk);
                    end
                    chk(done, "R8", "done after abandon", int'(done), 1);
                    chk(st_excess, "R8", "excess status", int'(st_excess), 1);
                    chk(int'(st_colls) == MAXT, "R8", "collision count", int'(st_colls), MAXT);
                    finished = 1;
                end else begin
                    int low = 0;
                    int lim;
                    lim = 1 << ((attempt < CAP) ? attempt : CAP);
                    while (!tx_en && low < 20000) begin
                        low++;
                        @(negedge clk);
                    end
                    chk(low >= 2 && (low - 2) % SLOT == 0, "R5", "backoff on slot grid",
                        low, 2);
                    chk((low - 2) / SLOT < lim, "R5", "backoff slots in range",
                        (low - 2) / SLOT, lim - 1);
                end
            end else begin
                for (int g = 0; g < IFG; g++) begin
                    chk(!tx_en && !done, "R6", "inter-frame gap", int'(tx_en), 0);
                    @(negedge clk);
                end
                chk(done, "R6", "done after gap", int'(done), 1);
                chk(st_lost == exp_lost, fd ? "R7" : "R3", "lost carrier",
                    int'(st_lost), int'(exp_lost));
                chk(!st_excess, "R9", "excess clear", int'(st_excess), 0);
                chk(int'(st_colls) == (fd ? 0 : ncoll), "R9", "collision count",
                    int'(st_colls), fd ? 0 : ncoll);
                finished = 1;
            end
        end
        @(negedge clk);
        chk(!done, "R6", "done is one cycle", int'(done), 0);
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(!tx_en && txd == 4'h0, "R10", "line idle in reset", int'(tx_en), 0);
        chk(!done && !st_lost && !st_excess && st_colls == '0, "R10",
            "status in reset", int'(st_colls), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!tx_en && !done, "R10", "idle after reset", int'(tx_en), 0);

        run_frame(4, 0, 0, 0, 0, 0);        // R2 clean frame, carrier at once
        run_frame(3, 0, 0, 0, 2, 5);        // R1 deferral on busy line
        run_frame(10, 0, 0, 0, -1, 0);      // R3 no carrier at all
        run_frame(10, 0, 0, 0, 9, 0);       // R3 carrier after the slot
        run_frame(10, 0, 0, 0, 7, 0);       // R3 carrier just inside the slot
        run_frame(5, 1, 1, 3, -1, 1);       // R7 full duplex, crs and col high
        run_frame(6, 0, 3, 4, 0, 0);        // R4 R5 R9 three collisions mid-frame
        run_frame(4, 0, 1, 0, 0, 0);        // R4 collision on the first nibble
        run_frame(4, 0, 2, 7, 0, 0);        // R4 collision on the last nibble
        run_frame(2, 0, 16, 1, 0, 0);       // R8 excessive collisions
        run_frame(1, 0, 0, 0, 0, 0);        // R2 one-byte frame after abandon

        summary();
        $finish;
    end

endmodule